// File: doc/BRIEF.md
# Chained Memory-to-Stream DMA Engine

This engine is the transmit half of a DMA channel. It walks a linked list of data descriptors held in memory, reads each described buffer region a word at a time over a simple request/acknowledge memory master port, and hands the bytes one by one to a ready/valid byte stream sink. When a descriptor's region has been fully sent, the engine writes the descriptor back, optionally raises an interrupt-set pulse, and then either follows the descriptor's next pointer or, at end of list, marks the owning context descriptor disabled and goes quiet.

A surrounding control block drives it. It first loads a context, which supplies the first descriptor pointer and the starting buffer pointer. It then issues a start. Once the list has ended, software may clear the end-of-list bit of the last descriptor in memory, link a new one, and issue a continue to resume without reloading the context. Configuration levels for enable and stop decide whether the channel may run, and the engine stalls cleanly on sink backpressure and on a stop request.

Top module: `chain_tx_dma`

## Requirements
- R1: A data descriptor is four 32-bit words at pointer +0, +4, +8 and +12: next pointer, buffer start, flags, and exclusive buffer end; flags bit 0 is end-of-list and bit 4 is interrupt-on-completion. All pointers are word-aligned.
- R2: The bytes from the buffer pointer up to end-1 appear on the stream in ascending address order; the byte at address a is bits [8*(a mod 4)+7 : 8*(a mod 4)] of the little-endian word read at a with its two low bits cleared. A region whose pointer equals its end sends no byte, and afterwards `buf_ptr_o` equals the end address.
- R3: While `st_valid_o` is high and `st_ready_i` is low, `st_valid_o` stays high and `st_data_o` stays unchanged, and no byte is lost or repeated.
- R4: After BURST_BYTES (default 2048) bytes of one region, the engine reads the current descriptor again before continuing from the saved buffer pointer, so a region of n > 0 bytes causes ceil(n/2048) reads of its first word.
- R5: When a region completes and its interrupt flag is set, `desc_irq_o` pulses for exactly one cycle; the four descriptor words are then written back unchanged.
- R6: When the completed descriptor has end-of-list clear, the engine moves to its next pointer, fetches that descriptor and restarts from its buffer start.
- R7: When the completed descriptor has end-of-list set, `eol_o` rises, the context flags word at context address +4 is written with bit 15 set and its other bits kept, and the engine goes idle with no stream activity.
- R8: A context load reads the words at context address +4, +24 and +28 into the kept context flags, the descriptor pointer and the buffer pointer.
- R9: A start is taken only while enabled and not stopped; it clears `eol_o` and sets `run_state_o` to running. The state codes are one-hot: 3'b001 reset, 3'b010 stopped, 3'b100 running.
- R10: A continue while running and with the current descriptor's end-of-list flag set refetches that descriptor; if its end-of-list is now clear and `eol_o` is set, the engine clears `eol_o`, moves to the next descriptor and transfers it; otherwise nothing is sent and `eol_o` stays set.
- R11: A high `cfg_stop` puts the state in stopped and no further buffer word is read until a start; a low `cfg_en` puts the state in reset.
- R12: A memory request holds its address, direction and write data until acknowledged, and every request address is word-aligned.
- R13: After reset the engine is idle, `eol_o` is low, the state is reset, and no memory request, stream valid or interrupt pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Channel enable level |
| cfg_stop | input | 1 | Channel stop level |
| start_i | input | 1 | Start pulse |
| cont_i | input | 1 | Continue pulse |
| ctx_load_i | input | 1 | Context load pulse |
| ctx_addr_i | input | AW | Context descriptor address |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory access is a write |
| mem_addr_o | output | AW | Word-aligned memory address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Memory access done (read data valid) |
| mem_rdata_i | input | 32 | Memory read data |
| st_valid_o | output | 1 | Stream byte valid |
| st_data_o | output | 8 | Stream byte |
| st_ready_i | input | 1 | Stream sink ready |
| desc_irq_o | output | 1 | Interrupt-set pulse on descriptor completion |
| eol_o | output | 1 | Channel has reached end of list |
| run_state_o | output | 3 | One-hot channel state |
| busy_o | output | 1 | Engine is sequencing |
| desc_ptr_o | output | AW | Current descriptor pointer |
| buf_ptr_o | output | AW | Current buffer pointer |

## Verification
A wrong buffer pointer or lane offset shows on the very next stream byte as a wrong value, and a lost progress update after a burst refetch shows as repeated or missing bytes within one word of the burst boundary. A wrong descriptor decision (chain versus end of list) shows within a few memory accesses as a write to the wrong address, a missing context write with bit 15, or `eol_o` rising too early or never. Errors in the continue path show as bytes sent when none are due, or a stalled engine whose `desc_ptr_o` never reaches the newly linked descriptor.

// File: rtl/ctd_pkg.sv
package ctd_pkg;
  localparam int WORD_W     = 32;
  localparam int DESC_WORDS = 4;
  localparam int IX_W       = $clog2(DESC_WORDS);

  // descriptor word positions, relative to the descriptor pointer
  localparam int IX_NEXT  = 0;
  localparam int IX_START = 1;
  localparam int IX_FLAGS = 2;
  localparam int IX_END   = 3;

  // flag bit positions
  localparam int FLG_EOL     = 0;
  localparam int FLG_INTR    = 4;
  localparam int CTX_DIS_BIT = 15;

  // context word byte offsets
  localparam int CTX_FLG_OFF  = 4;
  localparam int CTX_DPTR_OFF = 24;
  localparam int CTX_BPTR_OFF = 28;

  typedef enum logic [2:0] {
    RS_RST  = 3'b001,
    RS_STOP = 3'b010,
    RS_RUN  = 3'b100
  } run_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_CTX_RD,
    SQ_D_RD,
    SQ_CHECK,
    SQ_W_RD,
    SQ_EMIT,
    SQ_D_WR,
    SQ_C_WR
  } seq_e;
endpackage

// File: rtl/ctd_run_state.sv
module ctd_run_state
  import ctd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_en,
  input  logic cfg_stop,
  input  logic start_acc,
  output run_e run_st
);
  run_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (!cfg_en)        st_d = RS_RST;
    else if (cfg_stop)  st_d = RS_STOP;
    else if (start_acc) st_d = RS_RUN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= RS_RST;
    else        st_q <= st_d;
  end

  assign run_st = st_q;
endmodule

// File: rtl/ctd_desc_file.sv
module ctd_desc_file #(
  parameter int W    = 32,
  parameter int N    = 4,
  localparam int XW  = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [XW-1:0]  wr_idx,
  input  logic [W-1:0]   wr_data,
  output logic [N*W-1:0] words_o
);
  for (genvar g = 0; g < N; g++) begin : g_word
    logic [W-1:0] q;
    logic         hit;
    assign hit = wr_en && (wr_idx == XW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (hit) q <= wr_data;
    end
    assign words_o[g*W +: W] = q;
  end
endmodule

// File: rtl/ctd_byte_pick.sv
module ctd_byte_pick #(
  parameter int W    = 32,
  localparam int LN  = W / 8,
  localparam int OW  = $clog2(LN)
) (
  input  logic [W-1:0]  word_i,
  input  logic [OW-1:0] off_i,
  output logic [7:0]    byte_o
);
  logic [LN-1:0][7:0] lanes;

  for (genvar g = 0; g < LN; g++) begin : g_lane
    assign lanes[g] = word_i[g*8 +: 8];
  end

  assign byte_o = lanes[off_i];
endmodule

// File: rtl/chain_tx_dma.sv
module chain_tx_dma
  import ctd_pkg::*;
#(
  parameter int AW          = 32,
  parameter int BURST_BYTES = 2048
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_en,
  input  logic          cfg_stop,
  input  logic          start_i,
  input  logic          cont_i,
  input  logic          ctx_load_i,
  input  logic [AW-1:0] ctx_addr_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [31:0]   mem_rdata_i,
  output logic          st_valid_o,
  output logic [7:0]    st_data_o,
  input  logic          st_ready_i,
  output logic          desc_irq_o,
  output logic          eol_o,
  output logic [2:0]    run_state_o,
  output logic          busy_o,
  output logic [AW-1:0] desc_ptr_o,
  output logic [AW-1:0] buf_ptr_o
);
  localparam int BC_W = $clog2(BURST_BYTES + 1);
  localparam int LOW  = $clog2(WORD_W / 8);

  seq_e              seq_q, seq_d;
  logic [IX_W-1:0]   idx_q, idx_d;
  logic [AW-1:0]     dptr_q, dptr_d, bptr_q, bptr_d;
  logic [WORD_W-1:0] cflg_q, cflg_d, word_q, word_d;
  logic              eol_q, eol_d;
  logic              reload_q, reload_d;
  logic              cont_q, cont_d;
  logic              irq_q, irq_d;
  logic [BC_W-1:0]   burst_q, burst_d;

  logic                         dwr_en;
  logic [DESC_WORDS*WORD_W-1:0] dwords;
  logic [WORD_W-1:0]            d_flags, d_word_sel;
  logic [AW-1:0]                d_next, d_start, d_end;
  logic [AW-1:0]                nxt_b;
  logic [WORD_W-1:0]            cflg_dis;
  run_e                         run_st;
  logic                         running, start_acc;

  // ---------------------------------------------------------------- children
  ctd_run_state u_run (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_en    (cfg_en),
    .cfg_stop  (cfg_stop),
    .start_acc (start_acc),
    .run_st    (run_st)
  );

  ctd_desc_file #(.W(WORD_W), .N(DESC_WORDS)) u_desc (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (dwr_en),
    .wr_idx  (idx_q),
    .wr_data (mem_rdata_i),
    .words_o (dwords)
  );

  ctd_byte_pick #(.W(WORD_W)) u_pick (
    .word_i (word_q),
    .off_i  (bptr_q[LOW-1:0]),
    .byte_o (st_data_o)
  );

  // ---------------------------------------------------------------- decode
  assign d_next     = dwords[IX_NEXT*WORD_W  +: AW];
  assign d_start    = dwords[IX_START*WORD_W +: AW];
  assign d_flags    = dwords[IX_FLAGS*WORD_W +: WORD_W];
  assign d_end      = dwords[IX_END*WORD_W   +: AW];
  assign d_word_sel = dwords[idx_q*WORD_W    +: WORD_W];
  assign nxt_b      = bptr_q + AW'(1);
  assign cflg_dis   = cflg_q | (WORD_W'(1) << CTX_DIS_BIT);
  assign running    = (run_st == RS_RUN);
  assign start_acc  = start_i && cfg_en && !cfg_stop &&
                      ((seq_q == SQ_IDLE) || ((seq_q == SQ_CHECK) && !running));

  // ---------------------------------------------------------------- memory port
  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unique case (seq_q)
      SQ_CTX_RD: begin
        mem_req_o = 1'b1;
        unique case (idx_q)
          2'd0:    mem_addr_o = ctx_addr_i + AW'(CTX_FLG_OFF);
          2'd1:    mem_addr_o = ctx_addr_i + AW'(CTX_DPTR_OFF);
          default: mem_addr_o = ctx_addr_i + AW'(CTX_BPTR_OFF);
        endcase
      end
      SQ_D_RD: begin
        mem_req_o  = 1'b1;
        mem_addr_o = dptr_q + AW'({idx_q, 2'b00});
      end
      SQ_W_RD: begin
        mem_req_o  = 1'b1;
        mem_addr_o = {bptr_q[AW-1:LOW], LOW'(0)};
      end
      SQ_D_WR: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = dptr_q + AW'({idx_q, 2'b00});
        mem_wdata_o = d_word_sel;
      end
      SQ_C_WR: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = ctx_addr_i + AW'(CTX_FLG_OFF);
        mem_wdata_o = cflg_dis;
      end
      default: ;
    endcase
  end

  // ---------------------------------------------------------------- next state
  always_comb begin
    seq_d    = seq_q;
    idx_d    = idx_q;
    dptr_d   = dptr_q;
    bptr_d   = bptr_q;
    cflg_d   = cflg_q;
    word_d   = word_q;
    eol_d    = eol_q;
    reload_d = reload_q;
    cont_d   = cont_q;
    burst_d  = burst_q;
    irq_d    = 1'b0;
    dwr_en   = 1'b0;

    unique case (seq_q)
      SQ_IDLE: begin
        if (ctx_load_i) begin
          idx_d = '0;
          seq_d = SQ_CTX_RD;
        end else if (start_acc) begin
          eol_d    = 1'b0;
          idx_d    = '0;
          reload_d = 1'b0;
          cont_d   = 1'b0;
          seq_d    = SQ_D_RD;
        end else if (cont_i && running && d_flags[FLG_EOL]) begin
          idx_d  = '0;
          cont_d = 1'b1;
          seq_d  = SQ_D_RD;
        end
      end

      SQ_CTX_RD: begin
        if (mem_ack_i) begin
          idx_d = idx_q + 1'b1;
          unique case (idx_q)
            2'd0: cflg_d = mem_rdata_i;
            2'd1: dptr_d = mem_rdata_i[AW-1:0];
            default: begin
              bptr_d = mem_rdata_i[AW-1:0];
              idx_d  = '0;
              seq_d  = SQ_IDLE;
            end
          endcase
        end
      end

      SQ_D_RD: begin
        if (mem_ack_i) begin
          dwr_en = 1'b1;
          idx_d  = idx_q + 1'b1;
          if (idx_q == IX_W'(DESC_WORDS - 1)) begin
            idx_d = '0;
            if (cont_q) begin
              cont_d = 1'b0;
              if (!d_flags[FLG_EOL] && eol_q) begin
                eol_d    = 1'b0;
                dptr_d   = d_next;
                reload_d = 1'b1;
              end else begin
                seq_d = SQ_IDLE;
              end
            end else begin
              if (reload_q) bptr_d = d_start;
              reload_d = 1'b0;
              burst_d  = '0;
              seq_d    = SQ_CHECK;
            end
          end
        end
      end

      SQ_CHECK: begin
        if (bptr_q == d_end) begin
          irq_d = d_flags[FLG_INTR];
          idx_d = '0;
          seq_d = SQ_D_WR;
        end else if (running) begin
          seq_d = SQ_W_RD;
        end
      end

      SQ_W_RD: begin
        if (mem_ack_i) begin
          word_d = mem_rdata_i;
          seq_d  = SQ_EMIT;
        end
      end

      SQ_EMIT: begin
        if (st_ready_i) begin
          bptr_d  = nxt_b;
          burst_d = burst_q + 1'b1;
          if (nxt_b == d_end) begin
            seq_d = SQ_CHECK;
          end else if (burst_q + 1'b1 == BC_W'(BURST_BYTES)) begin
            idx_d = '0;
            seq_d = SQ_D_RD;
          end else if (nxt_b[LOW-1:0] == '0) begin
            seq_d = SQ_CHECK;
          end
        end
      end

      SQ_D_WR: begin
        if (mem_ack_i) begin
          idx_d = idx_q + 1'b1;
          if (idx_q == IX_W'(DESC_WORDS - 1)) begin
            idx_d = '0;
            if (d_flags[FLG_EOL]) begin
              eol_d = 1'b1;
              seq_d = SQ_C_WR;
            end else begin
              dptr_d   = d_next;
              reload_d = 1'b1;
              seq_d    = SQ_D_RD;
            end
          end
        end
      end

      SQ_C_WR: begin
        if (mem_ack_i) begin
          cflg_d = cflg_dis;
          seq_d  = SQ_IDLE;
        end
      end

      default: seq_d = SQ_IDLE;
    endcase
  end

  // ---------------------------------------------------------------- registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q    <= SQ_IDLE;
      idx_q    <= '0;
      dptr_q   <= '0;
      bptr_q   <= '0;
      cflg_q   <= '0;
      word_q   <= '0;
      eol_q    <= 1'b0;
      reload_q <= 1'b0;
      cont_q   <= 1'b0;
      irq_q    <= 1'b0;
      burst_q  <= '0;
    end else begin
      seq_q    <= seq_d;
      idx_q    <= idx_d;
      dptr_q   <= dptr_d;
      bptr_q   <= bptr_d;
      cflg_q   <= cflg_d;
      word_q   <= word_d;
      eol_q    <= eol_d;
      reload_q <= reload_d;
      cont_q   <= cont_d;
      irq_q    <= irq_d;
      burst_q  <= burst_d;
    end
  end

  // ---------------------------------------------------------------- outputs
  assign st_valid_o  = (seq_q == SQ_EMIT);
  assign desc_irq_o  = irq_q;
  assign eol_o       = eol_q;
  assign run_state_o = run_st;
  assign busy_o      = (seq_q != SQ_IDLE);
  assign desc_ptr_o  = dptr_q;
  assign buf_ptr_o   = bptr_q;
endmodule

// File: rtl/ctd_chk.sv
module ctd_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [31:0]   mem_wdata_o,
  input logic          mem_ack_i,
  input logic          st_valid_o,
  input logic [7:0]    st_data_o,
  input logic          st_ready_i,
  input logic          desc_irq_o,
  input logic          eol_o,
  input logic [2:0]    run_state_o
);
  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) &&
                                $stable(mem_we_o) && $stable(mem_wdata_o));

  assert_addr_align_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00);

  assert_stream_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid_o && !st_ready_i |=> st_valid_o && $stable(st_data_o));

  assert_irq_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    desc_irq_o |=> !desc_irq_o);

  assert_quiet_eol_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eol_o |-> !st_valid_o && !desc_irq_o);

  assert_state_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(run_state_o) == 1);
endmodule

bind chain_tx_dma ctd_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ack_i   (mem_ack_i),
  .st_valid_o  (st_valid_o),
  .st_data_o   (st_data_o),
  .st_ready_i  (st_ready_i),
  .desc_irq_o  (desc_irq_o),
  .eol_o       (eol_o),
  .run_state_o (run_state_o)
);

// File: tb/tb_chain_tx_dma.sv
module tb_chain_tx_dma;
  localparam int CLK_P    = 10;
  localparam int WD_LIMIT = 150000;
  localparam int BURST    = 2048;
  localparam logic [31:0] D0  = 32'h100;
  localparam logic [31:0] D1  = 32'h140;
  localparam logic [31:0] D2  = 32'h180;
  localparam logic [31:0] CTX = 32'h200;
  localparam int NV = 6;
  // {buffer start, exclusive end}
  localparam logic [63:0] VEC [NV] = '{
    {32'h1000, 32'h1010},
    {32'h1003, 32'h1011},
    {32'h1004, 32'h100B},
    {32'h1102, 32'h1103},
    {32'h1200, 32'h1200},
    {32'h1000, 32'h1834}
  };

  logic clk, rst_n, cfg_en, cfg_stop, start_i, cont_i, ctx_load_i;
  logic [31:0] ctx_addr_i;
  logic mem_req_o, mem_we_o, mem_ack_i;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic st_valid_o, st_ready_i, desc_irq_o, eol_o, busy_o;
  logic [7:0] st_data_o;
  logic [2:0] run_state_o;
  logic [31:0] desc_ptr_o, buf_ptr_o;

  chain_tx_dma dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_stop(cfg_stop),
    .start_i(start_i), .cont_i(cont_i), .ctx_load_i(ctx_load_i),
    .ctx_addr_i(ctx_addr_i), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i),
    .mem_rdata_i(mem_rdata_i), .st_valid_o(st_valid_o), .st_data_o(st_data_o),
    .st_ready_i(st_ready_i), .desc_irq_o(desc_irq_o), .eol_o(eol_o),
    .run_state_o(run_state_o), .busy_o(busy_o), .desc_ptr_o(desc_ptr_o),
    .buf_ptr_o(buf_ptr_o)
  );

  int checks = 0, errors = 0, cyc = 0;
  logic [31:0] mem [0:2047];
  logic [7:0]  rx  [0:4095];
  logic [7:0]  exq [0:4095];
  int rx_n, ex_n, irq_cnt, d0_rd, d0_wr, misal, rdy_mode;

  function automatic logic [7:0] fb(input logic [31:0] a);
    return (a[7:0] * 8'd5) ^ a[11:4];
  endfunction

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  always #(CLK_P/2) clk = ~clk;

  // memory model: one-cycle acknowledge pulse per request
  always @(negedge clk) begin
    if (mem_ack_i) mem_ack_i = 1'b0;
    else if (mem_req_o) begin
      if (mem_addr_o[1:0] != 2'b00) misal++;
      if (mem_we_o) begin
        mem[mem_addr_o[12:2]] = mem_wdata_o;
        if (mem_addr_o >= D0 && mem_addr_o < D0 + 16) d0_wr++;
      end else begin
        mem_rdata_i = mem[mem_addr_o[12:2]];
        if (mem_addr_o == D0) d0_rd++;
      end
      mem_ack_i = 1'b1;
    end
  end

  // sink: ready pattern plus byte capture (handshake at the coming edge)
  always @(negedge clk) begin
    logic r;
    r = (rdy_mode == 0) ? 1'b1 : (cyc % 3 != 0);
    st_ready_i = r;
    if (st_valid_o && r) begin
      rx[rx_n] = st_data_o;
      rx_n++;
    end
    if (desc_irq_o) irq_cnt++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD_LIMIT) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, WD_LIMIT);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 20000 && busy_o; k++) @(negedge clk);
  endtask

  task automatic put_desc(input logic [31:0] a, nx, s, fl, e);
    mem[a[12:2]]     = nx;
    mem[a[12:2] + 1] = s;
    mem[a[12:2] + 2] = fl;
    mem[a[12:2] + 3] = e;
  endtask

  task automatic put_ctx(input logic [31:0] fl, dp, bp);
    mem[CTX[12:2] + 1] = fl;
    mem[CTX[12:2] + 6] = dp;
    mem[CTX[12:2] + 7] = bp;
  endtask

  task automatic add_exp(input logic [31:0] s, e);
    for (logic [31:0] a = s; a < e; a++) begin
      exq[ex_n] = fb(a);
      ex_n++;
    end
  endtask

  task automatic clr();
    rx_n = 0; ex_n = 0; irq_cnt = 0; d0_rd = 0; d0_wr = 0;
  endtask

  task automatic cmp_data(input string tag);
    int bad;
    bad = 0;
    for (int k = 0; k < ex_n && k < rx_n; k++) if (rx[k] != exq[k]) bad++;
    chk(rx_n == ex_n, {tag, " byte count"}, rx_n, ex_n);
    chk(bad == 0, {tag, " byte values"}, bad, 0);
  endtask

  initial begin
    clk = 0; rst_n = 0; cfg_en = 0; cfg_stop = 0; start_i = 0; cont_i = 0;
    ctx_load_i = 0; ctx_addr_i = CTX; mem_ack_i = 0; mem_rdata_i = '0;
    st_ready_i = 1; rdy_mode = 0; misal = 0;
    clr();
    for (int w = 0; w < 2048; w++)
      for (int b = 0; b < 4; b++) mem[w][b*8 +: 8] = fb(32'(w*4 + b));
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R13: reset state
    chk(busy_o == 0 && !mem_req_o, "R13 idle after reset", busy_o, 0);
    chk(eol_o == 0, "R13 eol after reset", eol_o, 0);
    chk(run_state_o == 3'b001, "R13 state after reset", run_state_o, 1);
    chk(!st_valid_o && !desc_irq_o, "R13 stream quiet", st_valid_o, 0);
    cfg_en = 1;

    // table of single-descriptor regions, R1 R2 R3 R4 R7 R8 R9
    for (int v = 0; v < NV; v++) begin
      logic [31:0] s, e;
      int n, exp_rd;
      s = VEC[v][63:32]; e = VEC[v][31:0]; n = int'(e - s);
      exp_rd = (n == 0) ? 1 : (n + BURST - 1) / BURST;
      clr(); rdy_mode = v % 2;
      put_desc(D0, 32'h0, s, 32'h1, e);
      put_ctx(32'h0000_00A5, D0, s);
      pulse(ctx_load_i); wait_idle();
      chk(desc_ptr_o == D0 && buf_ptr_o == s, "R8 context pointers", buf_ptr_o, s);
      pulse(start_i);
      chk(run_state_o == 3'b100, "R9 running after start", run_state_o, 4);
      wait_idle();
      add_exp(s, e);
      cmp_data("R1 R2 R3 region");
      chk(buf_ptr_o == e, "R2 final buffer pointer", buf_ptr_o, e);
      chk(d0_rd == exp_rd, "R4 descriptor reads", d0_rd, exp_rd);
      chk(eol_o == 1, "R7 eol raised", eol_o, 1);
      chk(mem[CTX[12:2] + 1] == 32'h0000_80A5, "R7 context disable bit",
          mem[CTX[12:2] + 1], 32'h80A5);
    end
    rdy_mode = 0;

    // R5 R6: two-descriptor chain, interrupt on the first
    clr();
    put_desc(D0, D1, 32'h1000, 32'h10, 32'h1008);
    put_desc(D1, 32'h0, 32'h1400, 32'h1, 32'h1404);
    put_ctx(32'h0, D0, 32'h1000);
    pulse(ctx_load_i); wait_idle();
    pulse(start_i); wait_idle();
    add_exp(32'h1000, 32'h1008); add_exp(32'h1400, 32'h1404);
    cmp_data("R6 chain");
    chk(desc_ptr_o == D1, "R6 pointer followed next", desc_ptr_o, D1);
    chk(irq_cnt == 1, "R5 interrupt pulses", irq_cnt, 1);
    chk(d0_wr == 4 && mem[D0[12:2] + 2] == 32'h10, "R5 descriptor write-back", d0_wr, 4);

    // R10: continue while end-of-list is still set does nothing
    clr();
    pulse(cont_i); wait_idle(); repeat (10) @(negedge clk);
    chk(rx_n == 0, "R10 no bytes on idle continue", rx_n, 0);
    chk(eol_o == 1 && desc_ptr_o == D1, "R10 still at end of list", desc_ptr_o, D1);

    // R10: clear end-of-list, link a new descriptor, continue
    clr();
    put_desc(D1, D2, 32'h1400, 32'h0, 32'h1404);
    put_desc(D2, 32'h0, 32'h1500, 32'h1, 32'h1503);
    pulse(cont_i); wait_idle();
    add_exp(32'h1500, 32'h1503);
    cmp_data("R10 resumed");
    chk(desc_ptr_o == D2 && eol_o == 1, "R10 reached new end", desc_ptr_o, D2);

    // R11: stop in the middle of a region, then resume with a start
    clr();
    put_desc(D0, 32'h0, 32'h1000, 32'h1, 32'h1100);
    put_ctx(32'h0, D0, 32'h1000);
    pulse(ctx_load_i); wait_idle();
    pulse(start_i);
    for (int k = 0; k < 2000 && rx_n < 20; k++) @(negedge clk);
    cfg_stop = 1;
    repeat (2) @(negedge clk);
    chk(run_state_o == 3'b010, "R11 stopped state", run_state_o, 2);
    repeat (20) @(negedge clk);
    begin
      int n1;
      n1 = rx_n;
      repeat (40) @(negedge clk);
      chk(rx_n == n1 && rx_n < 256, "R11 no bytes while stopped", rx_n, n1);
    end
    cfg_stop = 0;
    pulse(start_i); wait_idle();
    add_exp(32'h1000, 32'h1100);
    cmp_data("R11 resumed region");

    // R9: start ignored while stopped; R11: disable gives reset state
    cfg_stop = 1;
    @(negedge clk);
    pulse(start_i);
    @(negedge clk);
    chk(run_state_o == 3'b010 && !busy_o, "R9 start refused when stopped", run_state_o, 2);
    cfg_en = 0;
    repeat (2) @(negedge clk);
    chk(run_state_o == 3'b001, "R11 disabled state", run_state_o, 1);
    chk(misal == 0, "R12 aligned requests", misal, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule